// File: doc/BRIEF.md
# Parallel Hot-Swap Chain Fault Sequencer

This block is the digital sequencer of the primary switch in a chain of hot-swap switches wired in parallel. All switches share one open-drain enable line. Any device can pull it low, and it reads high only when every device has let go. The sequencer holds that line low until its own bias and trim are ready, then releases it and waits for the combined line to read high. It then turns its gate on for the start-up ramp and drives power-good once the ramp has finished.

In steady state the block watches digitised current, input voltage and output voltage. An overcurrent that lasts longer than a programmable blanking window makes it pull the shared line low, so the whole chain opens at the same moment. Input under- or overvoltage also pulls the line low. A fast current trip either latches the chain off or restarts it directly in the current-limited ramp, as a configuration bit selects. If another device pulls the line low, the block turns its own gate off. A sticky fault flag records every shutdown that this block starts.

Top module: `efuse_chain_seq`

## Requirements
- R1: After reset, and whenever enable is low, the block is in state INIT (code 0). In INIT it pulls the shared line low, keeps the gate off and pulls power-good low. It moves to WAIT_EN (code 1) on the clock edge where enable and initDone are both high, and then releases the line.
- R2: The gate turns on (state INRUSH, code 2) only after the synchronised line reads high with no recent own drive. While the line is held low by another device, the block stays in WAIT_EN with the gate off.
- R3: Power-good stays pulled low during INRUSH. It is released on the edge where gateHigh moves the block to STEADY (code 3). After that it is pulled low only while voutCode < voutPgTh.
- R4: An overcurrent detect in STEADY enters OC_BLANK (code 4). If the detect drops before the window ends, the block returns to STEADY with no fault.
- R5: If overcurrent lasts for ocTimerCfg × OC_UNIT cycles in OC_BLANK (minimum 1), the block enters LATCHED (code 6), pulls the line low, turns the gate off and sets the fault flag.
- R6: If the line reads low from outside while the block is not driving it (INRUSH, STEADY or OC_BLANK), the gate turns off and the block returns to WAIT_EN without setting the fault flag.
- R7: When vinCode < vinUvTh or vinCode > vinOvTh in WAIT_EN, INRUSH, STEADY or OC_BLANK, the block enters SHUTDOWN (code 5), pulls the line low and sets the fault flag. When both conditions clear, it goes to INIT.
- R8: The fast trip fires in INRUSH when 2 × current > 3 × ilimLevel. In STEADY or OC_BLANK it fires when current > 2 × ocLevel or current ≥ FIXED_FT. A current exactly at either limit does not trip.
- R9: A fast trip sets the fault flag. With scRetry = 1 the block goes straight to INRUSH. With scRetry = 0 it goes to LATCHED.
- R10: LATCHED is left when enable goes low (to INIT) or, when retryCfg ≠ 0, through RETRY_WAIT (code 7). RETRY_WAIT lasts retryCfg × RETRY_UNIT cycles and then returns to INIT. With retryCfg = 0 the block stays latched.
- R11: The fault flag is sticky. It clears on a clearFaults pulse or on a rising edge of enable. A set in the same cycle wins over a clear.
- R12: dbgState shows the current state with the codes listed in R1 to R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Chain enable; a low level restarts the sequence |
| initDone | input | 1 | Internal bias and trim ready |
| swenIn | input | 1 | Readback of the shared open-drain enable line (asynchronous) |
| ocDetect | input | 1 | Steady-state overcurrent comparator output |
| gateHigh | input | 1 | Start-up ramp has reached full gate drive |
| currentCode | input | CUR_W | Digitised load current |
| ilimLevel | input | CUR_W | Start-up current limit |
| ocLevel | input | CUR_W | Steady-state overcurrent level |
| vinCode | input | V_W | Digitised input voltage |
| vinUvTh | input | V_W | Input undervoltage threshold |
| vinOvTh | input | V_W | Input overvoltage threshold |
| voutCode | input | V_W | Digitised output voltage |
| voutPgTh | input | V_W | Output power-good threshold |
| ocTimerCfg | input | 8 | Overcurrent blanking length in units of OC_UNIT cycles |
| retryCfg | input | RETRY_W | Auto-retry delay in units of RETRY_UNIT cycles; 0 disables retry |
| scRetry | input | 1 | Fast-trip action: 1 restart, 0 latch |
| clearFaults | input | 1 | Clears the fault flag |
| swenPullDown | output | 1 | Pulls the shared enable line low |
| pgPullDown | output | 1 | Pulls the shared power-good line low |
| faultFlag | output | 1 | Sticky fault indication |
| gateOn | output | 1 | Gate drive command |
| dbgState | output | 3 | Current sequencer state code |

## Verification
Assertions check on every cycle that:
- INIT is only left with enable and initDone high, and the gate only rises after the line was seen high;
- power-good is only released from a finished ramp or a recovered output;
- OC_BLANK is only held while overcurrent is present, and SHUTDOWN is only entered on a voltage fault;
- the fault flag only rises from a shutdown decision and stays set until a clear.

The directed scenarios cover the rest: the exact length of the blanking and retry windows, the trip points at their boundaries, the difference between an external line drop and a self-started shutdown, and the two fast-trip responses.

// File: rtl/efuse_seq_pkg.sv
package efuse_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT       = 3'd0,
    ST_WAIT_EN    = 3'd1,
    ST_INRUSH     = 3'd2,
    ST_STEADY     = 3'd3,
    ST_OC_BLANK   = 3'd4,
    ST_SHUTDOWN   = 3'd5,
    ST_LATCHED    = 3'd6,
    ST_RETRY_WAIT = 3'd7
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic cntClr;    // restart the shared window counter
    logic cntRun;    // advance the window counter
    logic selRetry;  // compare against the retry delay instead of blanking
    logic faultSet;  // a self-started shutdown was decided this cycle
  } seqStrobe_t;

endpackage

// File: rtl/efuse_seq_dp.sv
module efuse_seq_dp
  import efuse_seq_pkg::*;
#(
  parameter int CUR_W       = 10,
  parameter int V_W         = 10,
  parameter int OC_CFG_W    = 8,
  parameter int RETRY_W     = 4,
  parameter int OC_UNIT     = 4,
  parameter int RETRY_UNIT  = 8,
  parameter int FIXED_FT    = 900,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic               pullDown,
  input  logic               swenIn,
  input  logic               enable,
  input  logic               clearFaults,
  input  logic [CUR_W-1:0]   currentCode,
  input  logic [CUR_W-1:0]   ilimLevel,
  input  logic [CUR_W-1:0]   ocLevel,
  input  logic [V_W-1:0]     vinCode,
  input  logic [V_W-1:0]     vinUvTh,
  input  logic [V_W-1:0]     vinOvTh,
  input  logic [V_W-1:0]     voutCode,
  input  logic [V_W-1:0]     voutPgTh,
  input  logic [OC_CFG_W-1:0] ocTimerCfg,
  input  logic [RETRY_W-1:0] retryCfg,
  output logic               swenHigh,
  output logic               swenLowExt,
  output logic               underVolt,
  output logic               overVolt,
  output logic               ftInrush,
  output logic               ftSteady,
  output logic               voutLow,
  output logic               tmrExpired,
  output logic               faultFlag
);

  localparam int OC_LIM_W  = OC_CFG_W + $clog2(OC_UNIT + 1);
  localparam int RET_LIM_W = RETRY_W + $clog2(RETRY_UNIT + 1);
  localparam int CNT_W     = (OC_LIM_W > RET_LIM_W) ? OC_LIM_W : RET_LIM_W;
  localparam int FT_W      = CUR_W + 3;

  // ---------------- shared line synchroniser with own-drive mask
  logic [SYNC_STAGES-1:0] syncQ;
  logic [SYNC_STAGES-1:0] drvHist;
  logic                   ownMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      drvHist <= '1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], swenIn};
      drvHist <= {drvHist[SYNC_STAGES-2:0], pullDown};
    end
  end

  assign ownMask    = pullDown | (|drvHist);
  assign swenHigh   =  syncQ[SYNC_STAGES-1] & ~ownMask;
  assign swenLowExt = ~syncQ[SYNC_STAGES-1] & ~ownMask;

  // ---------------- threshold comparisons
  assign underVolt = vinCode < vinUvTh;
  assign overVolt  = vinCode > vinOvTh;
  assign voutLow   = voutCode < voutPgTh;

  logic [FT_W-1:0] curX2, curX1, ilimX3, ocX2;
  assign curX1  = FT_W'(currentCode);
  assign curX2  = FT_W'(currentCode) * FT_W'(2);
  assign ilimX3 = FT_W'(ilimLevel) * FT_W'(3);
  assign ocX2   = FT_W'(ocLevel) * FT_W'(2);

  assign ftInrush = curX2 > ilimX3;
  assign ftSteady = (curX1 > ocX2) || (curX1 >= FT_W'(FIXED_FT));

  // ---------------- shared window counter (blanking and retry delay)
  logic [CNT_W-1:0] tmrCnt;
  logic [CNT_W-1:0] ocLim, retLim, curLim;

  assign ocLim  = CNT_W'(ocTimerCfg) * CNT_W'(OC_UNIT);
  assign retLim = CNT_W'(retryCfg) * CNT_W'(RETRY_UNIT);
  assign curLim = strb.selRetry ? retLim : ocLim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tmrCnt <= '0;
    else if (strb.cntClr) tmrCnt <= '0;
    else if (strb.cntRun) tmrCnt <= tmrCnt + 1'b1;
  end

  assign tmrExpired = ({1'b0, tmrCnt} + (CNT_W+1)'(1)) >= {1'b0, curLim};

  // ---------------- sticky fault flag
  logic enPrev;
  logic faultClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enable;
  end

  assign faultClr = clearFaults | (enable & ~enPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              faultFlag <= 1'b0;
    else if (strb.faultSet) faultFlag <= 1'b1;
    else if (faultClr)      faultFlag <= 1'b0;
  end

  // R11: the flag holds unless a clear arrives
  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !faultClr) |=> faultFlag);

  // R11: the flag only rises from a shutdown decision
  assert_fault_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultFlag) |-> $past(strb.faultSet));

endmodule

// File: rtl/efuse_seq_ctrl.sv
module efuse_seq_ctrl
  import efuse_seq_pkg::*;
#(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               initDone,
  input  logic               ocDetect,
  input  logic               gateHigh,
  input  logic               scRetry,
  input  logic [RETRY_W-1:0] retryCfg,
  input  logic               swenHigh,
  input  logic               swenLowExt,
  input  logic               underVolt,
  input  logic               overVolt,
  input  logic               ftInrush,
  input  logic               ftSteady,
  input  logic               voutLow,
  input  logic               tmrExpired,
  output seqState_t          state,
  output seqStrobe_t         strb,
  output logic               swenPullDown,
  output logic               pgPullDown,
  output logic               gateOn
);

  seqState_t nxt;
  logic      vinBad;

  assign vinBad = underVolt | overVolt;

  always_comb begin
    nxt  = state;
    strb = '0;
    unique case (state)
      ST_INIT: begin
        if (enable && initDone) nxt = ST_WAIT_EN;
      end
      ST_WAIT_EN: begin
        if (!enable)       nxt = ST_INIT;
        else if (vinBad) begin
          nxt = ST_SHUTDOWN;
          strb.faultSet = 1'b1;
        end
        else if (swenHigh) nxt = ST_INRUSH;
      end
      ST_INRUSH: begin
        if (!enable) nxt = ST_INIT;
        else if (vinBad) begin
          nxt = ST_SHUTDOWN;
          strb.faultSet = 1'b1;
        end
        else if (ftInrush) begin
          nxt = scRetry ? ST_INRUSH : ST_LATCHED;
          strb.faultSet = 1'b1;
        end
        else if (swenLowExt) nxt = ST_WAIT_EN;
        else if (gateHigh)   nxt = ST_STEADY;
      end
      ST_STEADY: begin
        if (!enable) nxt = ST_INIT;
        else if (vinBad) begin
          nxt = ST_SHUTDOWN;
          strb.faultSet = 1'b1;
        end
        else if (ftSteady) begin
          nxt = scRetry ? ST_INRUSH : ST_LATCHED;
          strb.faultSet = 1'b1;
        end
        else if (swenLowExt) nxt = ST_WAIT_EN;
        else if (ocDetect) begin
          nxt = ST_OC_BLANK;
          strb.cntClr = 1'b1;
        end
      end
      ST_OC_BLANK: begin
        strb.cntRun = 1'b1;
        if (!enable) nxt = ST_INIT;
        else if (vinBad) begin
          nxt = ST_SHUTDOWN;
          strb.faultSet = 1'b1;
        end
        else if (ftSteady) begin
          nxt = scRetry ? ST_INRUSH : ST_LATCHED;
          strb.faultSet = 1'b1;
        end
        else if (swenLowExt) nxt = ST_WAIT_EN;
        else if (!ocDetect)  nxt = ST_STEADY;
        else if (tmrExpired) begin
          nxt = ST_LATCHED;
          strb.faultSet = 1'b1;
        end
      end
      ST_SHUTDOWN: begin
        if (!enable || !vinBad) nxt = ST_INIT;
      end
      ST_LATCHED: begin
        if (!enable) nxt = ST_INIT;
        else if (|retryCfg) begin
          nxt = ST_RETRY_WAIT;
          strb.cntClr = 1'b1;
        end
      end
      ST_RETRY_WAIT: begin
        strb.cntRun   = 1'b1;
        strb.selRetry = 1'b1;
        if (!enable || tmrExpired) nxt = ST_INIT;
      end
      default: nxt = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INIT;
    else       state <= nxt;
  end

  assign swenPullDown = state inside {ST_INIT, ST_SHUTDOWN, ST_LATCHED, ST_RETRY_WAIT};
  assign gateOn       = state inside {ST_INRUSH, ST_STEADY, ST_OC_BLANK};
  assign pgPullDown   = !((state inside {ST_STEADY, ST_OC_BLANK}) && !voutLow);

  // R1: INIT is left only with enable and initDone both high
  assert_init_exit_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_INIT && state != ST_INIT) |-> $past(enable && initDone));

  // R2: gate turn-on follows a clean high readback of the shared line
  assert_gate_needs_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> ($past(swenHigh) || $past(ftInrush)));

  // R3: power-good release comes from a finished ramp or a recovered output
  assert_pg_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pgPullDown) |-> ($past(gateHigh) || $past(state) inside {ST_STEADY, ST_OC_BLANK}));

  // R4: blanking is only held while overcurrent is present
  assert_blank_needs_oc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OC_BLANK) |-> $past(ocDetect));

  // R7: entry into SHUTDOWN needs an input voltage fault
  assert_shutdown_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) != ST_SHUTDOWN && state == ST_SHUTDOWN) |-> $past(vinBad));

  // R10: the retry wait ends on timer expiry or on disable
  assert_retry_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_RETRY_WAIT && state == ST_INIT) |-> ($past(tmrExpired) || !$past(enable)));

endmodule

// File: rtl/efuse_chain_seq.sv
module efuse_chain_seq
  import efuse_seq_pkg::*;
#(
  parameter int CUR_W       = 10,
  parameter int V_W         = 10,
  parameter int RETRY_W     = 4,
  parameter int OC_UNIT     = 4,
  parameter int RETRY_UNIT  = 8,
  parameter int FIXED_FT    = 900,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               initDone,
  input  logic               swenIn,
  input  logic               ocDetect,
  input  logic               gateHigh,
  input  logic [CUR_W-1:0]   currentCode,
  input  logic [CUR_W-1:0]   ilimLevel,
  input  logic [CUR_W-1:0]   ocLevel,
  input  logic [V_W-1:0]     vinCode,
  input  logic [V_W-1:0]     vinUvTh,
  input  logic [V_W-1:0]     vinOvTh,
  input  logic [V_W-1:0]     voutCode,
  input  logic [V_W-1:0]     voutPgTh,
  input  logic [7:0]         ocTimerCfg,
  input  logic [RETRY_W-1:0] retryCfg,
  input  logic               scRetry,
  input  logic               clearFaults,
  output logic               swenPullDown,
  output logic               pgPullDown,
  output logic               faultFlag,
  output logic               gateOn,
  output logic [2:0]         dbgState
);

  seqState_t  state;
  seqStrobe_t strb;
  logic swenHigh, swenLowExt, underVolt, overVolt;
  logic ftInrush, ftSteady, voutLow, tmrExpired;

  efuse_seq_ctrl #(.RETRY_W(RETRY_W)) u_ctrl (
    .clk, .rstN, .enable, .initDone, .ocDetect, .gateHigh, .scRetry, .retryCfg,
    .swenHigh, .swenLowExt, .underVolt, .overVolt, .ftInrush, .ftSteady,
    .voutLow, .tmrExpired, .state, .strb, .swenPullDown, .pgPullDown, .gateOn
  );

  efuse_seq_dp #(
    .CUR_W(CUR_W), .V_W(V_W), .OC_CFG_W(8), .RETRY_W(RETRY_W),
    .OC_UNIT(OC_UNIT), .RETRY_UNIT(RETRY_UNIT), .FIXED_FT(FIXED_FT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk, .rstN, .strb, .pullDown(swenPullDown), .swenIn, .enable, .clearFaults,
    .currentCode, .ilimLevel, .ocLevel, .vinCode, .vinUvTh, .vinOvTh,
    .voutCode, .voutPgTh, .ocTimerCfg, .retryCfg,
    .swenHigh, .swenLowExt, .underVolt, .overVolt, .ftInrush, .ftSteady,
    .voutLow, .tmrExpired, .faultFlag
  );

  assign dbgState = state;

endmodule

// File: tb/efuse_chain_seq_bench.sv
module efuse_chain_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int CUR_W = 10, V_W = 10, RETRY_W = 4;
  localparam int OC_UNIT = 4, RETRY_UNIT = 8;

  localparam int S_INIT = 0, S_WAIT = 1, S_INRUSH = 2, S_STEADY = 3;
  localparam int S_BLANK = 4, S_SHUT = 5, S_LATCH = 6, S_RETRY = 7;

  logic clk = 1'b0, rstN = 1'b0;
  logic enable = 0, initDone = 0, ocDetect = 0, gateHigh = 0, scRetry = 0, clearFaults = 0;
  logic secPd = 0;
  logic [CUR_W-1:0] currentCode = 100, ilimLevel = 200, ocLevel = 250;
  logic [V_W-1:0] vinCode = 500, vinUvTh = 300, vinOvTh = 700, voutCode = 500, voutPgTh = 400;
  logic [7:0] ocTimerCfg = 8'd3;
  logic [RETRY_W-1:0] retryCfg = '0;
  logic swenPullDown, pgPullDown, faultFlag, gateOn;
  logic [2:0] dbgState;
  logic swenLine;

  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain wired line: high only when nobody pulls it
  assign swenLine = !swenPullDown && !secPd;

  efuse_chain_seq u_efuse_chain_seq (
    .clk, .rstN, .enable, .initDone, .swenIn(swenLine), .ocDetect, .gateHigh,
    .currentCode, .ilimLevel, .ocLevel, .vinCode, .vinUvTh, .vinOvTh,
    .voutCode, .voutPgTh, .ocTimerCfg, .retryCfg, .scRetry, .clearFaults,
    .swenPullDown, .pgPullDown, .faultFlag, .gateOn, .dbgState
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitState(input int st, input int maxc, input string req);
    int n = 0;
    while (int'(dbgState) != st && n < maxc) begin
      cyc(1);
      n++;
    end
    check(req, int'(dbgState), st);
  endtask

  task automatic pulseClear();
    clearFaults = 1'b1;
    cyc(1);
    clearFaults = 1'b0;
    check("R11 clear pulse", int'(faultFlag), 0);
  endtask

  task automatic bringUp();
    gateHigh = 1'b0;
    secPd    = 1'b0;
    waitState(S_INRUSH, 12, "R2 reach inrush");
    check("R2 gate on", int'(gateOn), 1);
    gateHigh = 1'b1;
    cyc(1);
    check("R3 steady", int'(dbgState), S_STEADY);
  endtask

  task automatic t_reset();
    enable = 1'b1;
    initDone = 1'b0;
    secPd = 1'b1;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    check("R12 reset state", int'(dbgState), S_INIT);
    check("R1 line held", int'(swenPullDown), 1);
    check("R1 gate off", int'(gateOn), 0);
    check("R1 pg low", int'(pgPullDown), 1);
    check("R11 reset flag", int'(faultFlag), 0);
    cyc(5);
    check("R1 wait init", int'(dbgState), S_INIT);
    initDone = 1'b1;
    cyc(1);
    check("R1 release", int'(dbgState), S_WAIT);
    check("R1 line released", int'(swenPullDown), 0);
  endtask

  task automatic t_startup();
    cyc(6);
    check("R2 held by other", int'(dbgState), S_WAIT);
    check("R2 gate stays off", int'(gateOn), 0);
    secPd = 1'b0;
    waitState(S_INRUSH, 8, "R2 inrush");
    check("R3 pg low inrush", int'(pgPullDown), 1);
    cyc(3);
    check("R3 still inrush", int'(dbgState), S_INRUSH);
    check("R3 pg still low", int'(pgPullDown), 1);
    gateHigh = 1'b1;
    cyc(1);
    check("R3 steady", int'(dbgState), S_STEADY);
    check("R3 pg released", int'(pgPullDown), 0);
    voutCode = 350;
    cyc(1);
    check("R3 pg on low vout", int'(pgPullDown), 1);
    check("R3 stays steady", int'(dbgState), S_STEADY);
    voutCode = 500;
    cyc(1);
    check("R3 pg recovers", int'(pgPullDown), 0);
  endtask

  task automatic t_oc_short();
    ocDetect = 1'b1;
    cyc(1);
    check("R4 blank", int'(dbgState), S_BLANK);
    cyc(3);
    ocDetect = 1'b0;
    cyc(1);
    check("R4 back steady", int'(dbgState), S_STEADY);
    check("R4 no fault", int'(faultFlag), 0);
  endtask

  task automatic t_oc_expire();
    int n = 0;
    ocDetect = 1'b1;
    cyc(1);
    while (int'(dbgState) == S_BLANK && n < 200) begin
      n++;
      cyc(1);
    end
    check("R5 blank length", n, 3 * OC_UNIT);
    check("R5 latched", int'(dbgState), S_LATCH);
    check("R5 line low", int'(swenPullDown), 1);
    check("R5 gate off", int'(gateOn), 0);
    check("R5 fault", int'(faultFlag), 1);
    ocDetect = 1'b0;
    cyc(20);
    check("R10 no retry", int'(dbgState), S_LATCH);
  endtask

  task automatic t_reenable();
    enable = 1'b0;
    cyc(1);
    check("R10 disable exit", int'(dbgState), S_INIT);
    check("R11 flag held", int'(faultFlag), 1);
    enable = 1'b1;
    cyc(1);
    check("R11 enable rise clears", int'(faultFlag), 0);
    check("R1 re-release", int'(dbgState), S_WAIT);
    bringUp();
  endtask

  task automatic t_ext_low();
    secPd = 1'b1;
    waitState(S_WAIT, 8, "R6 ext low");
    check("R6 gate off", int'(gateOn), 0);
    check("R6 no fault", int'(faultFlag), 0);
    bringUp();
  endtask

  task automatic t_volt();
    vinCode = 250;
    cyc(1);
    check("R7 uv shutdown", int'(dbgState), S_SHUT);
    check("R7 line low", int'(swenPullDown), 1);
    check("R7 gate off", int'(gateOn), 0);
    check("R7 fault", int'(faultFlag), 1);
    cyc(3);
    check("R7 holds", int'(dbgState), S_SHUT);
    vinCode = 500;
    cyc(1);
    check("R7 to init", int'(dbgState), S_INIT);
    cyc(1);
    check("R7 restart", int'(dbgState), S_WAIT);
    pulseClear();
    vinCode = 750;
    cyc(1);
    check("R7 ov shutdown", int'(dbgState), S_SHUT);
    check("R7 ov fault", int'(faultFlag), 1);
    vinCode = 500;
    cyc(2);
    check("R7 ov restart", int'(dbgState), S_WAIT);
    pulseClear();
    bringUp();
  endtask

  task automatic t_ft_steady();
    int n = 0;
    currentCode = 500;
    cyc(1);
    check("R8 boundary 2x", int'(dbgState), S_STEADY);
    currentCode = 501;
    cyc(1);
    check("R9 latch on trip", int'(dbgState), S_LATCH);
    check("R9 fault", int'(faultFlag), 1);
    currentCode = 100;
    retryCfg = 4'd2;
    cyc(1);
    check("R10 retry wait", int'(dbgState), S_RETRY);
    while (int'(dbgState) == S_RETRY && n < 200) begin
      n++;
      cyc(1);
    end
    check("R10 retry length", n, 2 * RETRY_UNIT);
    check("R10 retry exit", int'(dbgState), S_INIT);
    retryCfg = '0;
    pulseClear();
    bringUp();
    ocLevel = 600;
    currentCode = 899;
    cyc(1);
    check("R8 fixed boundary", int'(dbgState), S_STEADY);
    currentCode = 900;
    scRetry = 1'b1;
    gateHigh = 1'b0;
    cyc(1);
    check("R9 restart inrush", int'(dbgState), S_INRUSH);
    check("R9 restart fault", int'(faultFlag), 1);
    check("R9 pg low", int'(pgPullDown), 1);
    check("R9 gate on", int'(gateOn), 1);
    currentCode = 100;
    ocLevel = 250;
    pulseClear();
  endtask

  task automatic t_ft_inrush();
    currentCode = 300;
    cyc(1);
    check("R8 inrush boundary", int'(dbgState), S_INRUSH);
    check("R8 no fault", int'(faultFlag), 0);
    currentCode = 301;
    cyc(1);
    check("R9 inrush restart", int'(dbgState), S_INRUSH);
    check("R8 inrush trip", int'(faultFlag), 1);
    scRetry = 1'b0;
    cyc(1);
    check("R9 inrush latch", int'(dbgState), S_LATCH);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_oc_short();
    t_oc_expire();
    t_reenable();
    t_ext_low();
    t_volt();
    t_ft_steady();
    t_ft_inrush();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule